// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block arbitrates interrupts for a small processor core. It has four sources: an asynchronous external pin, a 12-bit timer, a basic timer and a serial unit. Each source has a pending flag and a mask bit. A global enable bit is set by an enable-interrupts strobe and cleared by a disable-interrupts strobe. The pending flags and mask bits combine into one "active" line per source. A grant token then passes down a fixed chain from the highest priority source to the lowest. The first active source keeps the token, so only that source is acknowledged.

On an acknowledge the controller does four things. It clears the winner's pending flag. It clears the global enable so that a second interrupt cannot nest. It raises a one-cycle acknowledge pulse. It drives the winner's vector number, which stays on the output until the next acknowledge. Software reaches the flags through a small register port. This port reads the pending or mask bits, loads the mask bits, and clears pending bits by writing ones.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on `ext_pin` sets pending bit 3 on the third rising clock edge after the edge is sampled. The path is two synchronizer flops and then edge detection. A pin held high sets the bit only once.
- R2: A one-cycle high on `t12_req`, `btm_req` or `ser_req` sets pending bit 2, bit 1 or bit 0 respectively, at the same clock edge.
- R3: An acknowledge happens only when the global enable is 1 and at least one source has both its pending bit and its mask bit at 1.
- R4: When more than one source is active, the winner is chosen by bit index, highest first: pin (3), then 12-bit timer (2), then basic timer (1), then serial (0). `ack_pulse` is high for exactly one cycle. `ack_vec` carries the winner's vector, which defaults to 3, 2, 1 and 0 respectively, and holds that value until the next acknowledge.
- R5: An acknowledge clears only the winner's pending bit. The pending bits of all other sources are left unchanged.
- R6: A source whose mask bit is 0 is never acknowledged, even if it has the highest priority. Its pending bit stays set.
- R7: `ei_strobe` sets the global enable and `di_strobe` clears it. When both strobes arrive in the same cycle, the disable wins.
- R8: An acknowledge clears the global enable, so a second acknowledge needs a fresh `ei_strobe`.
- R9: A set request for a source wins over a clear in the same cycle. This holds whether the clear comes from an acknowledge or from a software write.
- R10: Register port reads have one cycle of latency.
  - `reg_sel`=0 returns the pending bits in `reg_rdata`; `reg_sel`=1 returns the mask bits.
  - A write with `reg_sel`=1 loads the mask bits from `reg_wdata`.
  - A write with `reg_sel`=0 clears every pending bit whose `reg_wdata` bit is 1.
- R11: `rst` is synchronous and active high. It clears all pending bits, all mask bits, the global enable, `ack_pulse`, `ack_vec` and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| t12_req | input | 1 | 12-bit timer request pulse |
| btm_req | input | 1 | Basic timer request pulse |
| ser_req | input | 1 | Serial unit request pulse |
| ei_strobe | input | 1 | Set global enable |
| di_strobe | input | 1 | Clear global enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: pending bits, 1: mask bits |
| reg_wdata | input | 4 | Write data, bit index = source |
| reg_rdata | output | 4 | Registered read data |
| ack_pulse | output | 1 | One-cycle acknowledge |
| ack_vec | output | 2 | Vector of the last winner |

## Verification
The hardest case to reach is a new request that arrives in the very cycle its own pending bit is being cleared. The stimulus first leaves a serial request pending while the global enable is off. It then issues the enable strobe and times a fresh pulse for the cycle in which the acknowledge fires. A second case drives a software clear and a pulse on the same source together. Priority and masking use a run-up with all flags set, and a run-up where the pin is pending but masked while a lower source wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N   = 4;
  localparam int SRC_SER = 0;
  localparam int SRC_BT  = 1;
  localparam int SRC_T12 = 2;
  localparam int SRC_PIN = 3;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  // R1
  single_rise_chk: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] ack_clr,
  input  logic [N-1:0] sw_clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] mask_q
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic pend_bit;
    logic mask_bit;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_bit <= 1'b0;
        mask_bit <= 1'b0;
      end else begin
        pend_bit <= set_req[i] | (pend_bit & ~(ack_clr[i] | sw_clr[i]));
        if (mask_we) mask_bit <= mask_wdata[i];
      end
    end

    assign pend_q[i] = pend_bit;
    assign mask_q[i] = mask_bit;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_req[i] |=> pend_q[i]);
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (ack_clr[i] && !set_req[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
  parameter int N  = 4,
  parameter int VW = 2
) (
  input  logic                  token_in,
  input  logic [N-1:0]          active,
  input  logic [N-1:0][VW-1:0]  vec_tab,
  output logic [N-1:0]          grant,
  output logic                  hit,
  output logic [VW-1:0]         vec
);
  logic [N:0] token;
  assign token[N] = token_in;

  for (genvar i = N - 1; i >= 0; i--) begin : g_link
    assign grant[i] = token[i+1] & active[i];
    assign token[i] = token[i+1] & ~active[i];
  end

  assign hit = |grant;

  always_comb begin
    vec = '0;
    for (int i = 0; i < N; i++) begin
      vec = vec | (vec_tab[i] & {VW{grant[i]}});
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int                VEC_W       = 2,
  parameter logic [VEC_W-1:0]  VEC_PIN     = 2'h3,
  parameter logic [VEC_W-1:0]  VEC_T12     = 2'h2,
  parameter logic [VEC_W-1:0]  VEC_BT      = 2'h1,
  parameter logic [VEC_W-1:0]  VEC_SER     = 2'h0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin,
  input  logic              t12_req,
  input  logic              btm_req,
  input  logic              ser_req,
  input  logic              ei_strobe,
  input  logic              di_strobe,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [SRC_N-1:0]  reg_wdata,
  output logic [SRC_N-1:0]  reg_rdata,
  output logic              ack_pulse,
  output logic [VEC_W-1:0]  ack_vec
);
  logic                         pin_rise;
  logic [SRC_N-1:0]             set_req;
  logic [SRC_N-1:0]             pend_q;
  logic [SRC_N-1:0]             mask_q;
  logic [SRC_N-1:0]             grant;
  logic [SRC_N-1:0]             sw_clr;
  logic [SRC_N-1:0][VEC_W-1:0]  vec_tab;
  logic                         hit;
  logic [VEC_W-1:0]             win_vec;
  logic                         gie_q;
  logic                         mask_we;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) i_pin_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_pin),
    .rise (pin_rise)
  );

  always_comb begin
    set_req          = '0;
    set_req[SRC_PIN] = pin_rise;
    set_req[SRC_T12] = t12_req;
    set_req[SRC_BT]  = btm_req;
    set_req[SRC_SER] = ser_req;
    vec_tab          = '0;
    vec_tab[SRC_PIN] = VEC_PIN;
    vec_tab[SRC_T12] = VEC_T12;
    vec_tab[SRC_BT]  = VEC_BT;
    vec_tab[SRC_SER] = VEC_SER;
  end

  assign mask_we = reg_wr && (reg_sel == SEL_MASK);
  assign sw_clr  = (reg_wr && (reg_sel == SEL_PEND)) ? reg_wdata : '0;

  irq_flag_bank #(.N(SRC_N)) i_flags (
    .clk        (clk),
    .rst        (rst),
    .set_req    (set_req),
    .ack_clr    (grant),
    .sw_clr     (sw_clr),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .pend_q     (pend_q),
    .mask_q     (mask_q)
  );

  irq_prio_chain #(.N(SRC_N), .VW(VEC_W)) i_chain (
    .token_in (gie_q),
    .active   (pend_q & mask_q),
    .vec_tab  (vec_tab),
    .grant    (grant),
    .hit      (hit),
    .vec      (win_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q     <= 1'b0;
      ack_pulse <= 1'b0;
      ack_vec   <= '0;
      reg_rdata <= '0;
    end else begin
      if (hit || di_strobe) gie_q <= 1'b0;
      else if (ei_strobe)   gie_q <= 1'b1;
      ack_pulse <= hit;
      if (hit) ack_vec <= win_vec;
      reg_rdata <= (reg_sel == SEL_MASK) ? mask_q : pend_q;
    end
  end

  // R4
  one_winner_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R6
  masked_never_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~mask_q) == '0);
  // R3
  ack_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pulse) |-> $past(gie_q));
  // R8
  no_back_to_back_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> !gie_q);
  // R7
  di_clears_chk: assert property (@(posedge clk) disable iff (rst)
    di_strobe |=> !gie_q);
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b0, t12_req = 1'b0, btm_req = 1'b0, ser_req = 1'b0;
  logic ei_strobe = 1'b0, di_strobe = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic [3:0] reg_rdata;
  logic       ack_pulse;
  logic [1:0] ack_vec;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, started = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .t12_req(t12_req),
    .btm_req(btm_req), .ser_req(ser_req), .ei_strobe(ei_strobe),
    .di_strobe(di_strobe), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_pulse(ack_pulse),
    .ack_vec(ack_vec)
  );

  // Behavioural reference model
  int m_pend, m_mask, m_gie, m_ack, m_vec, m_rd;
  int s1, s2, s3;

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_mask = 0; m_gie = 0; m_ack = 0; m_vec = 0; m_rd = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int act, win, nxt, setv, clrv;
      act = m_pend & m_mask;
      win = -1;
      if (m_gie != 0) begin
        for (int i = 0; i < 4; i++) if (act[i]) win = i;
      end
      m_rd = reg_sel ? m_mask : m_pend;
      setv = {28'd0, (s2 == 1 && s3 == 0), t12_req, btm_req, ser_req};
      clrv = (reg_wr && !reg_sel) ? int'(reg_wdata) : 0;
      if (win >= 0) clrv = clrv | (1 << win);
      nxt = setv | (m_pend & ~clrv);
      m_pend = nxt & 15;
      if (reg_wr && reg_sel) m_mask = int'(reg_wdata);
      if (win >= 0 || di_strobe) m_gie = 0;
      else if (ei_strobe) m_gie = 1;
      m_ack = (win >= 0) ? 1 : 0;
      if (win >= 0) m_vec = win;
      s3 = s2; s2 = s1; s1 = int'(ext_pin);
    end
    started = 1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R4 ack_pulse vs model", int'(ack_pulse), m_ack);
      chk("R4 ack_vec vs model", int'(ack_vec), m_vec);
      chk("R10 reg_rdata vs model", int'(reg_rdata), m_rd);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic sel, int exp, string tag);
    reg_sel = sel;
    step();
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(logic sel, logic [3:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = 4'h0;
  endtask

  task automatic do_ei();
    ei_strobe = 1'b1; step(); ei_strobe = 1'b0; step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 ack_pulse after reset", int'(ack_pulse), 0);
    rd(1'b0, 0, "R11 pending after reset");
    rd(1'b1, 0, "R11 mask after reset");

    // R2 pulse sets pending bit 2; no ack while masked/disabled (R3)
    t12_req = 1'b1; step(); t12_req = 1'b0;
    rd(1'b0, 4, "R2 t12 sets bit2");
    wr(1'b1, 4'hF);
    step();
    chk("R3 no ack without global enable", int'(ack_pulse), 0);
    do_ei();
    chk("R4 t12 ack pulse", int'(ack_pulse), 1);
    chk("R4 t12 vector", int'(ack_vec), 2);
    rd(1'b0, 0, "R5 winner cleared");

    // R1, R4 priority with pin, basic timer and serial pending
    ser_req = 1'b1; btm_req = 1'b1; ext_pin = 1'b1; step();
    ser_req = 1'b0; btm_req = 1'b0;
    step(); step(); step();
    rd(1'b0, 11, "R1 pin sets bit3 with R2 pulses");
    do_ei();
    chk("R4 pin highest vector", int'(ack_vec), 3);
    rd(1'b0, 3, "R5 only pin cleared");
    do_ei();
    chk("R4 basic timer next", int'(ack_vec), 1);
    do_ei();
    chk("R4 serial last", int'(ack_vec), 0);
    repeat (5) step();
    rd(1'b0, 0, "R1 held pin does not re-set");
    ext_pin = 1'b0; repeat (3) step();

    // R6 masked pin never acknowledged
    wr(1'b1, 4'h7);
    ext_pin = 1'b1; repeat (4) step();
    btm_req = 1'b1; step(); btm_req = 1'b0;
    do_ei();
    chk("R6 masked pin skipped, bt wins", int'(ack_vec), 1);
    rd(1'b0, 8, "R6 masked pin stays pending");
    ei_strobe = 1'b1; step(); ei_strobe = 1'b0;
    step(); step();
    chk("R6 no ack for masked source", int'(ack_pulse), 0);
    di_strobe = 1'b1; step(); di_strobe = 1'b0;
    ext_pin = 1'b0;

    // R7 disable wins over enable
    ei_strobe = 1'b1; di_strobe = 1'b1; step();
    ei_strobe = 1'b0; di_strobe = 1'b0;
    wr(1'b1, 4'hF);
    step(); step();
    chk("R7 di wins over ei", int'(ack_pulse), 0);
    do_ei();
    chk("R7 ei then pin ack", int'(ack_vec), 3);

    // R8 ack clears global enable
    ser_req = 1'b1; step(); ser_req = 1'b0;
    step(); step();
    chk("R8 no ack after ack without ei", int'(ack_pulse), 0);
    rd(1'b0, 1, "R8 serial still pending");

    // R9 set wins over ack clear
    ei_strobe = 1'b1; step(); ei_strobe = 1'b0;
    ser_req = 1'b1; step(); ser_req = 1'b0;
    chk("R9 ack fires", int'(ack_pulse), 1);
    chk("R9 ack vector", int'(ack_vec), 0);
    rd(1'b0, 1, "R9 new request kept");

    // R10 write-1-to-clear and R9 set over software clear
    wr(1'b0, 4'h1);
    rd(1'b0, 0, "R10 w1c clears bit0");
    btm_req = 1'b1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 4'h2; step();
    btm_req = 1'b0; reg_wr = 1'b0; reg_wdata = 4'h0;
    rd(1'b0, 2, "R9 set beats software clear");
    wr(1'b0, 4'h2);
    rd(1'b0, 0, "R10 w1c clears bit1");
    rd(1'b1, 15, "R10 mask readback");

    // R11 reset mid-run
    ser_req = 1'b1; step(); ser_req = 1'b0;
    rst = 1'b1; step(); rst = 1'b0;
    rd(1'b0, 0, "R11 pending cleared by reset");
    rd(1'b1, 0, "R11 mask cleared by reset");
    step();
    finish_run();
  end
endmodule